// File: doc/BRIEF.md
# Configurable UART Frame Engine

This block turns a parallel word into an asynchronous serial frame on a transmit line, and rebuilds words from frames arriving on a receive line. The frame shape and bit timing are set by static configuration inputs: a 16-bit baud divisor, an oversampling select, a two-bit word-length code, a parity enable with an odd/even select, and a two-bit stop-bit code. The inputs are decoded every cycle into a bit period, a word length and a stop count. An invalid combination drops `cfg_ok` and blocks both directions from starting a frame.

The transmitter accepts a one-cycle `tx_start` pulse while idle. It captures the configuration and the word at that edge, and holds `tx_busy` until the last stop bit has gone out. The receiver passes the line through a synchronizer and waits for a falling edge. It checks the start bit half a bit later, then samples each following bit at its centre. Each received frame gives a one-cycle `rx_valid` pulse together with the data and the framing and parity flags, which are held until the next frame.

Top module: `uart_frame_engine`

## Requirements
- R1: The word-length code selects the frame's data field width W: 00 gives 8 bits, 01 gives 9 bits and 10 gives 7 bits. Code 11 makes `cfg_ok` low.
- R2: Stop-bit code 0 appends one high stop bit and code 2 appends two. Codes 1 and 3 make `cfg_ok` low.
- R3: With parity enabled, field position W-1 carries a parity bit computed over data bits 0..W-2. Odd select makes the count of ones in data plus parity odd, and even select makes it even. The received word reports that position as 0.
- R4: With 16x oversampling (`over8`=0), each bit lasts exactly `baud_div` clock cycles.
- R5: With 8x oversampling, each bit lasts ((div & 0xFFF0) | ((div & 7) << 1)) / 2 cycles. A divisor with bit 3 set makes `cfg_ok` low.
- R6: A divisor below 16 makes `cfg_ok` low. While `cfg_ok` is low, `tx_start` is ignored: `tx_busy` stays low and `tx_line` stays high.
- R7: `tx_line` is high whenever no frame is in flight. A frame is a low start bit, then the field bits LSB first, then the stop bits.
- R8: On the edge that accepts `tx_start`, the line drives the start bit. `tx_busy` stays high for exactly P·(1+W+S) cycles, where P is the bit period and S the stop count. A `tx_start` pulse during that time changes nothing.
- R9: Each frame received gives exactly one single-cycle `rx_valid` pulse. `rx_data` then holds the W field bits, zero-extended to 9 bits, with the parity position cleared as in R3.
- R10: A low pulse on `rx_line` that has ended before the start-bit midpoint produces no `rx_valid`. The receiver then takes the next frame normally.
- R11: A low level at the first stop bit's midpoint sets `rx_frame_err` together with `rx_valid`. The receiver waits for the line to go high before looking for a new start bit.
- R12: When the received parity bit disagrees with R3, `rx_parity_err` is set together with `rx_valid`. It is always 0 when parity is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_div | input | 16 | Baud divisor |
| over8 | input | 1 | 1 selects 8x oversampling divisor encoding |
| wlen_code | input | 2 | Word-length code |
| par_en | input | 1 | Parity enable |
| par_odd | input | 1 | 1 odd parity, 0 even |
| stop_code | input | 2 | Stop-bit code |
| cfg_ok | output | 1 | Configuration is valid |
| tx_start | input | 1 | Request to send `tx_data` |
| tx_data | input | 9 | Word to transmit |
| tx_line | output | 1 | Serial output, idles high |
| tx_busy | output | 1 | Frame in flight |
| rx_line | input | 1 | Serial input, asynchronous |
| rx_valid | output | 1 | One-cycle pulse per received frame |
| rx_data | output | 9 | Last received word |
| rx_frame_err | output | 1 | Last frame had a low stop bit |
| rx_parity_err | output | 1 | Last frame had a parity mismatch |

## Verification
The assertions assume the configuration inputs do not change while a frame is in flight. They also assume `tx_start` is a single-cycle pulse, although a pulse that arrives while busy is legal. The stimulus changes configuration only between frames, once the line has been idle for a few cycles. The receiver is fed either by looping the transmitter output back, or by a driver that holds each level for whole bit periods, so every sample lands in the middle of a stable bit.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

  localparam int DIV_W    = 16;
  localparam int MAX_W    = 9;
  localparam int MAX_STOP = 2;
  localparam int PAY_W    = MAX_W + MAX_STOP;
  localparam int IDX_W    = $clog2(PAY_W + 1);

  typedef struct packed {
    logic             ok;
    logic [DIV_W-1:0] period;
    logic [IDX_W-1:0] nbits;
    logic [1:0]       nstop;
    logic             par_en;
    logic             par_odd;
  } fe_cfg_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_REARM
  } rx_state_e;

  // Configuration decode: bit period, field width, stop count, validity.
  function automatic fe_cfg_t fe_decode(input logic [DIV_W-1:0] div,
                                        input logic over8,
                                        input logic [1:0] wlen,
                                        input logic pe,
                                        input logic po,
                                        input logic [1:0] stop);
    fe_cfg_t c;
    c.period  = over8 ? {1'b0, div[DIV_W-1:4], div[2:0]} : div;
    case (wlen)
      2'b01:   c.nbits = IDX_W'(9);
      2'b10:   c.nbits = IDX_W'(7);
      default: c.nbits = IDX_W'(8);
    endcase
    c.nstop   = (stop == 2'd2) ? 2'd2 : 2'd1;
    c.par_en  = pe;
    c.par_odd = po;
    c.ok      = (div >= DIV_W'(16)) && (wlen != 2'b11) &&
                ((stop == 2'd0) || (stop == 2'd2)) && !(over8 && div[3]);
    return c;
  endfunction

  // Bits following the start bit, LSB first; positions past the field are stop (1).
  function automatic logic [PAY_W-1:0] fe_payload(input logic [MAX_W-1:0] d,
                                                  input logic [IDX_W-1:0] nbits,
                                                  input logic pe,
                                                  input logic po);
    logic [PAY_W-1:0] p;
    logic [PAY_W-1:0] dext;
    logic             par;
    dext = {{(PAY_W-MAX_W){1'b1}}, d};
    par  = po;
    for (int i = 0; i < MAX_W; i++) begin
      if (i < int'(nbits) - 1) par = par ^ d[i];
    end
    for (int i = 0; i < PAY_W; i++) begin
      if (i < int'(nbits)) p[i] = (pe && (i == int'(nbits) - 1)) ? par : dext[i];
      else                 p[i] = 1'b1;
    end
    return p;
  endfunction

endpackage

// File: rtl/uart_fe_sync.sv
module uart_fe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b1;
        else if (g == 0) chain_q[g] <= d;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/uart_fe_tx.sv
module uart_fe_tx
  import uart_fe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  fe_cfg_t          cfg,
  input  logic             start,
  input  logic [MAX_W-1:0] data,
  output logic             line,
  output logic             busy,
  output logic             accept
);
  logic             busy_q, line_q;
  logic [PAY_W-1:0] pay_q;
  logic [IDX_W-1:0] idx_q, last_q;
  logic [DIV_W-1:0] cnt_q, period_q;

  assign accept = start && !busy_q && cfg.ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      line_q   <= 1'b1;
      pay_q    <= '1;
      idx_q    <= '0;
      last_q   <= '0;
      cnt_q    <= '0;
      period_q <= '0;
    end else if (accept) begin
      busy_q   <= 1'b1;
      line_q   <= 1'b0;
      pay_q    <= fe_payload(data, cfg.nbits, cfg.par_en, cfg.par_odd);
      idx_q    <= '0;
      last_q   <= cfg.nbits + IDX_W'(cfg.nstop);
      cnt_q    <= cfg.period - DIV_W'(1);
      period_q <= cfg.period;
    end else if (busy_q) begin
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - DIV_W'(1);
      end else if (idx_q == last_q) begin
        busy_q <= 1'b0;
        line_q <= 1'b1;
      end else begin
        line_q <= pay_q[0];
        pay_q  <= {1'b1, pay_q[PAY_W-1:1]};
        idx_q  <= idx_q + IDX_W'(1);
        cnt_q  <= period_q - DIV_W'(1);
      end
    end
  end

  assign line = line_q;
  assign busy = busy_q;
endmodule

// File: rtl/uart_fe_rx.sv
module uart_fe_rx
  import uart_fe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_ok,
  input  logic [DIV_W-1:0] cfg_period,
  input  logic [IDX_W-1:0] cfg_nbits,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic             line,
  output logic             valid,
  output logic [MAX_W-1:0] data,
  output logic             frame_err,
  output logic             parity_err,
  output logic             glitch
);
  rx_state_e        state_q;
  logic [DIV_W-1:0] cnt_q, period_q;
  logic [IDX_W-1:0] idx_q, nb_q;
  logic             par_q, odd_q;
  logic [MAX_W-1:0] sh_q, data_q;
  logic             valid_q, ferr_q, perr_q;
  logic             bit_tick;

  assign bit_tick = (cnt_q == '0);
  assign glitch   = (state_q == RX_START) && bit_tick && line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= RX_IDLE;
      cnt_q    <= '0;
      period_q <= '0;
      idx_q    <= '0;
      nb_q     <= '0;
      par_q    <= 1'b0;
      odd_q    <= 1'b0;
      sh_q     <= '0;
      data_q   <= '0;
      valid_q  <= 1'b0;
      ferr_q   <= 1'b0;
      perr_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      case (state_q)
        RX_IDLE: begin
          if (cfg_ok && !line) begin
            state_q  <= RX_START;
            cnt_q    <= (cfg_period >> 1) - DIV_W'(1);
            period_q <= cfg_period;
            nb_q     <= cfg_nbits;
            par_q    <= cfg_par_en;
            odd_q    <= cfg_par_odd;
          end
        end
        RX_START: begin
          if (!bit_tick) cnt_q <= cnt_q - DIV_W'(1);
          else if (line) state_q <= RX_IDLE;
          else begin
            state_q <= RX_DATA;
            cnt_q   <= period_q - DIV_W'(1);
            idx_q   <= '0;
            sh_q    <= '0;
          end
        end
        RX_DATA: begin
          if (!bit_tick) cnt_q <= cnt_q - DIV_W'(1);
          else begin
            sh_q[idx_q] <= line;
            cnt_q       <= period_q - DIV_W'(1);
            if (idx_q == nb_q - IDX_W'(1)) state_q <= RX_STOP;
            else idx_q <= idx_q + IDX_W'(1);
          end
        end
        RX_STOP: begin
          if (!bit_tick) cnt_q <= cnt_q - DIV_W'(1);
          else begin
            valid_q <= 1'b1;
            ferr_q  <= !line;
            perr_q  <= par_q && ((^sh_q) ^ odd_q);
            data_q  <= par_q ? (sh_q & ~(MAX_W'(1) << (nb_q - IDX_W'(1)))) : sh_q;
            state_q <= RX_REARM;
          end
        end
        default: begin
          if (line) state_q <= RX_IDLE;
        end
      endcase
    end
  end

  assign valid      = valid_q;
  assign data       = data_q;
  assign frame_err  = ferr_q;
  assign parity_err = perr_q;
endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine
  import uart_fe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             over8,
  input  logic [1:0]       wlen_code,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic [1:0]       stop_code,
  output logic             cfg_ok,
  input  logic             tx_start,
  input  logic [MAX_W-1:0] tx_data,
  output logic             tx_line,
  output logic             tx_busy,
  input  logic             rx_line,
  output logic             rx_valid,
  output logic [MAX_W-1:0] rx_data,
  output logic             rx_frame_err,
  output logic             rx_parity_err
);
  fe_cfg_t cfg_w;
  logic    rx_sync;
  logic    tx_accept;
  logic    rx_glitch;

  assign cfg_w  = fe_decode(baud_div, over8, wlen_code, par_en, par_odd, stop_code);
  assign cfg_ok = cfg_w.ok;

  uart_fe_tx tx_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg    (cfg_w),
    .start  (tx_start),
    .data   (tx_data),
    .line   (tx_line),
    .busy   (tx_busy),
    .accept (tx_accept)
  );

  uart_fe_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rx_line),
    .q     (rx_sync)
  );

  uart_fe_rx rx_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_ok      (cfg_w.ok),
    .cfg_period  (cfg_w.period),
    .cfg_nbits   (cfg_w.nbits),
    .cfg_par_en  (cfg_w.par_en),
    .cfg_par_odd (cfg_w.par_odd),
    .line        (rx_sync),
    .valid       (rx_valid),
    .data        (rx_data),
    .frame_err   (rx_frame_err),
    .parity_err  (rx_parity_err),
    .glitch      (rx_glitch)
  );
endmodule

// File: rtl/uart_fe_chk.sv
module uart_fe_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_start,
  input logic cfg_ok,
  input logic tx_busy,
  input logic tx_line,
  input logic tx_accept,
  input logic rx_valid,
  input logic rx_glitch
);
  // R7
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_line);

  // R8
  accept_drives_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_accept |=> (tx_busy && !tx_line));

  // R6
  bad_cfg_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && !tx_busy && !cfg_ok) |=> !tx_busy);

  // R9
  rx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R7
  frame_end_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> tx_line);

  // R10
  glitch_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_glitch |=> !rx_valid);
endmodule

bind uart_frame_engine uart_fe_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_start  (tx_start),
  .cfg_ok    (cfg_ok),
  .tx_busy   (tx_busy),
  .tx_line   (tx_line),
  .tx_accept (tx_accept),
  .rx_valid  (rx_valid),
  .rx_glitch (rx_glitch)
);

// File: tb/uart_frame_engine_tb_top.sv
`timescale 1ns/1ps
module uart_frame_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] baud_div = 16'd16;
  logic        over8 = 1'b0;
  logic [1:0]  wlen_code = 2'd0;
  logic        par_en = 1'b0, par_odd = 1'b0;
  logic [1:0]  stop_code = 2'd0;
  logic        cfg_ok;
  logic        tx_start = 1'b0;
  logic [8:0]  tx_data = '0;
  logic        tx_line, tx_busy;
  logic        loop_en = 1'b1;
  logic        rx_drv = 1'b1;
  logic        rx_line;
  logic        rx_valid, rx_frame_err, rx_parity_err;
  logic [8:0]  rx_data;

  int checks = 0;
  int errors = 0;
  int rx_cnt = 0;
  logic [8:0] cap_data;
  logic       cap_ferr, cap_perr;

  always #2.5 clk = ~clk;
  assign rx_line = loop_en ? tx_line : rx_drv;

  uart_frame_engine dut_i (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .over8(over8),
    .wlen_code(wlen_code), .par_en(par_en), .par_odd(par_odd),
    .stop_code(stop_code), .cfg_ok(cfg_ok), .tx_start(tx_start),
    .tx_data(tx_data), .tx_line(tx_line), .tx_busy(tx_busy),
    .rx_line(rx_line), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err)
  );

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      rx_cnt   = rx_cnt + 1;
      cap_data = rx_data;
      cap_ferr = rx_frame_err;
      cap_perr = rx_parity_err;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int bit_period(input logic [15:0] d, input logic o8);
    if (!o8) return int'(d);
    return (int'(d & 16'hFFF0) + (int'(d & 16'h0007) * 2)) / 2;
  endfunction

  task automatic set_cfg(input logic [15:0] d, input logic o8, input logic [1:0] w,
                         input logic pe, input logic po, input logic [1:0] s);
    @(negedge clk);
    baud_div = d; over8 = o8; wlen_code = w; par_en = pe; par_odd = po; stop_code = s;
    repeat (2) @(negedge clk);
  endtask

  task automatic loop_frame(input logic [8:0] data);
    int p, w, s, n, base, bad_c, nd, ones;
    logic exp_bit [0:11];
    logic line_bad, busy_bad;
    p = bit_period(baud_div, over8);
    w = (wlen_code == 2'd1) ? 9 : (wlen_code == 2'd2) ? 7 : 8;
    s = (stop_code == 2'd2) ? 2 : 1;
    n = 1 + w + s;
    ones = 0;
    for (int i = 0; i < w - 1; i++) ones += int'(data[i]);
    for (int j = 0; j < 12; j++) exp_bit[j] = 1'b1;
    exp_bit[0] = 1'b0;
    for (int i = 0; i < w; i++)
      exp_bit[i+1] = (par_en && i == w - 1) ? (((ones % 2) == 1) ^ par_odd) : data[i];
    check(cfg_ok == 1'b1, "R1", "cfg_ok for valid config", int'(cfg_ok), 1);
    base = rx_cnt;
    loop_en = 1'b1;
    tx_data = data;
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    line_bad = 1'b0; busy_bad = 1'b0; bad_c = -1;
    for (int c = 0; c <= p * n; c++) begin
      if (c < p * n) begin
        if (tx_line !== exp_bit[c / p] && !line_bad) begin line_bad = 1'b1; bad_c = c; end
        if (tx_busy !== 1'b1) busy_bad = 1'b1;
      end else begin
        if (tx_busy !== 1'b0 || tx_line !== 1'b1) busy_bad = 1'b1;
      end
      if (c == 2 * p) begin tx_start = 1'b1; tx_data = ~data; end
      else tx_start = 1'b0;
      @(negedge clk);
    end
    tx_start = 1'b0;
    // R7 R3 R4 R5: waveform bit by bit
    check(!line_bad, "R7", "tx waveform first bad cycle", bad_c, -1);
    // R8: busy length P*(1+W+S), mid-frame start ignored
    check(!busy_bad, "R8", "tx_busy window", int'(busy_bad), 0);
    nd = w - int'(par_en);
    // R9
    check(rx_cnt == base + 1, "R9", "rx frame count", rx_cnt - base, 1);
    check(cap_data == 9'((int'(data)) & ((1 << nd) - 1)), "R9", "rx data",
          int'(cap_data), (int'(data)) & ((1 << nd) - 1));
    // R12 R11
    check(!cap_perr && !cap_ferr, "R12", "rx error flags on clean frame",
          int'({cap_ferr, cap_perr}), 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic send_raw(input int p, input logic [15:0] bits, input int n);
    loop_en = 1'b0;
    for (int j = 0; j < n; j++) begin
      rx_drv = bits[j];
      repeat (p) @(negedge clk);
    end
    rx_drv = 1'b1;
  endtask

  task automatic bad_cfg(input logic [15:0] d, input logic o8, input logic [1:0] w,
                         input logic [1:0] s, input string req);
    logic moved;
    set_cfg(d, o8, w, 1'b0, 1'b0, s);
    check(cfg_ok == 1'b0, req, "cfg_ok for invalid config", int'(cfg_ok), 0);
    tx_start = 1'b1; tx_data = 9'h000;
    @(negedge clk);
    tx_start = 1'b0;
    moved = 1'b0;
    for (int c = 0; c < 40; c++) begin
      if (tx_busy !== 1'b0 || tx_line !== 1'b1) moved = 1'b1;
      @(negedge clk);
    end
    check(!moved, req, "tx stays idle on invalid config", int'(moved), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung actual=%0d expected=%0d", 190000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    logic [15:0] divs [0:3];
    logic        o8s  [0:3];
    divs[0] = 16'd16;    o8s[0] = 1'b0;
    divs[1] = 16'd19;    o8s[1] = 1'b0;
    divs[2] = 16'h0025;  o8s[2] = 1'b1;
    divs[3] = 16'h0020;  o8s[3] = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_line == 1'b1 && tx_busy == 1'b0 && rx_valid == 1'b0, "R7",
          "reset state", int'({tx_line, tx_busy, rx_valid}), 4);

    // Sweep of valid configurations in loopback: R1 R2 R3 R4 R5 R8 R9
    for (int di = 0; di < 4; di++)
      for (int w = 0; w < 3; w++)
        for (int pm = 0; pm < 3; pm++)
          for (int si = 0; si < 2; si++) begin
            set_cfg(divs[di], o8s[di], 2'(w), pm != 0, pm == 2, si ? 2'd2 : 2'd0);
            loop_frame(9'h1A5);
            loop_frame(9'h05A ^ 9'(di * 37 + w * 11 + pm * 5 + si));
          end

    // Invalid configurations
    bad_cfg(16'd15, 1'b0, 2'd0, 2'd0, "R6");
    bad_cfg(16'd16, 1'b0, 2'd3, 2'd0, "R1");
    bad_cfg(16'd16, 1'b0, 2'd0, 2'd1, "R2");
    bad_cfg(16'd16, 1'b0, 2'd0, 2'd3, "R2");
    bad_cfg(16'h0028, 1'b1, 2'd0, 2'd0, "R5");

    // R10: short low pulse is rejected, next frame taken
    set_cfg(16'd16, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0);
    loop_en = 1'b0;
    base = rx_cnt;
    rx_drv = 1'b0;
    repeat (5) @(negedge clk);
    rx_drv = 1'b1;
    repeat (200) @(negedge clk);
    check(rx_cnt == base, "R10", "no frame from glitch", rx_cnt - base, 0);
    send_raw(16, {6'b0, 1'b1, 8'h3C, 1'b0}, 10);
    repeat (20) @(negedge clk);
    check(rx_cnt == base + 1 && cap_data == 9'h03C && !cap_ferr, "R10",
          "frame after glitch", int'(cap_data), 'h3C);

    // R11: low stop bit
    base = rx_cnt;
    send_raw(16, {4'b0, 1'b0, 1'b0, 1'b0, 8'h55, 1'b0}, 12);
    repeat (20) @(negedge clk);
    check(rx_cnt == base + 1 && cap_ferr == 1'b1, "R11", "framing error flag",
          int'(cap_ferr), 1);
    check(cap_data == 9'h055, "R11", "data with framing error", int'(cap_data), 'h55);

    // R12: even parity, 7 data bits 0x13 needs parity 1; send 0
    set_cfg(16'd16, 1'b0, 2'd0, 1'b1, 1'b0, 2'd0);
    base = rx_cnt;
    send_raw(16, {6'b0, 1'b1, 1'b0, 7'h13, 1'b0}, 10);
    repeat (20) @(negedge clk);
    check(rx_cnt == base + 1 && cap_perr == 1'b1 && !cap_ferr, "R12",
          "parity error flag", int'(cap_perr), 1);
    check(cap_data == 9'h013, "R3", "data without parity position", int'(cap_data), 'h13);

    loop_en = 1'b1;
    repeat (10) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule